// File: doc/BRIEF.md
# Shared Serial EEPROM Access Arbiter

This block is the EEPROM-facing side of a configuration controller. It shares one three-wire serial EEPROM (chip select, serial clock, bidirectional serial data) with optional on-board logic. The two parties pass ownership with a pair of busy signals. `own_busy` is driven by the block. `ext_busy` comes from the other party and passes through a two-flop synchronizer before the state machine uses it.

Out of reset the block owns the bus at once. It raises `own_busy` and serves word reads that its configuration sequencer requests through `rd_start`/`rd_addr`. When `cfg_done` arrives, it drops `own_busy` and releases all serial pins, and the pins then read low through the pad pull-downs.

A `wake` pulse makes the block ask for the bus again by raising `own_busy`. It waits until the synchronized external busy reads low, then takes the pins. It then launches a read at word address 0x0E, where resource data starts, without any further command. Reads use the usual microwire-style frame. This suits 2-Kbit and 4-Kbit x16 parts with an 8-bit address field.

Top module: `eeprom_share_ctl`

## Requirements
- R1: After reset the block owns the bus with no waiting: `own_busy`=1, `ee_cs_oe`=1, `ee_sck_oe`=1, with chip select low until a read starts.
- R2: One cycle after `cfg_done` is sampled in configuration mode with no read running, `own_busy` and all three pin enables are 0.
- R3: Whenever `ee_cs_oe` is 0, `ee_cs_o`, `ee_sck_o`, `ee_sio_o`, `ee_sio_oe` and `ee_sck_oe` are all 0, so released pins resolve low.
- R4: After `own_busy` rises on a wake, the pins are enabled only after the synchronized `ext_busy` reads 0 (`ext_busy` low three cycles before the enable rises). If `ext_busy` went high two or more cycles before `own_busy`, the block keeps its enables off until it drops. The enables then rise exactly three cycles after the drop is sampled.
- R5: If `ext_busy` and `wake` are raised at the same clock edge while idle, the block takes the bus two cycles later and `ext_busy` is ignored.
- R6: With `ext_busy` tied low, `own_busy` rises one cycle after `wake` is sampled. The enables and chip select rise one cycle after that.
- R7: A wake grant launches, with no command, a read at word address 0x0E.
- R8: A read frame holds chip select high and sends start bit 1, opcode bits 1 then 0, and then the 8 address bits MSB first. It then clocks in 16 data bits MSB first. Each bit lasts two cycles, clock low then high, and data in is sampled at the end of the high cycle.
- R9: At the end of a read, `rd_done` is high for exactly one cycle and `rd_data` holds the 16-bit word.
- R10: `ee_sio_oe` is 1 while the block sends frame bits and 0 during the 16 data-in bits.
- R11: `rd_start` is ignored while the bus is released, and `ext_busy` is ignored while the block owns the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_done | input | 1 | Configuration finished, release bus |
| wake | input | 1 | Leave wait-for-key, reclaim bus |
| rd_start | input | 1 | Start a word read (configuration mode) |
| rd_addr | input | ADDR_W | Word address for `rd_start` |
| rd_done | output | 1 | One-cycle read completion pulse |
| rd_data | output | DATA_W | Word read |
| rd_busy | output | 1 | Read frame in progress |
| own_busy | output | 1 | Block owns or requests the bus |
| ext_busy | input | 1 | External logic owns or requests the bus |
| ee_cs_o | output | 1 | Chip select value |
| ee_cs_oe | output | 1 | Chip select enable |
| ee_sck_o | output | 1 | Serial clock value |
| ee_sck_oe | output | 1 | Serial clock enable |
| ee_sio_o | output | 1 | Serial data out value |
| ee_sio_oe | output | 1 | Serial data out enable |
| ee_sio_i | input | 1 | Serial data in |

## Verification
A wrong ownership state shows within one cycle. The pin enables rise while `own_busy` is low, or they turn on inside the window where external logic may be driving. The bench catches this by sampling the enables on the exact cycles of each handoff. A shifter or counter fault corrupts the captured command bits or the returned word for some address. The bench therefore compares all 256 addresses against an arithmetic model and reports the fault on that address's `rd_done`.

// File: rtl/eeprom_share_ctl.sv
module eeprom_share_ctl #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int WAKE_ADDR = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_done,
  input  logic              wake,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_busy,
  output logic              own_busy,
  input  logic              ext_busy,
  output logic              ee_cs_o,
  output logic              ee_cs_oe,
  output logic              ee_sck_o,
  output logic              ee_sck_oe,
  output logic              ee_sio_o,
  output logic              ee_sio_oe,
  input  logic              ee_sio_i
);
  localparam int HDR_W = 3 + ADDR_W;
  localparam int TOT   = HDR_W + DATA_W;
  localparam int CW    = $clog2(TOT + 1);
  localparam logic [CW-1:0] HDR_C  = CW'(HDR_W);
  localparam logic [CW-1:0] LAST_C = CW'(TOT - 1);

  typedef enum logic [1:0] {S_CFG, S_IDLE, S_REQ} st_t;

  st_t               st;
  logic              ext_m, ext_s;
  logic              run, ph, done_q;
  logic [CW-1:0]     cnt;
  logic [HDR_W-1:0]  sh_out;
  logic [DATA_W-1:0] sh_in;

  wire owned    = (st == S_CFG);
  wire grant    = (st == S_REQ) && !ext_s;
  wire cmd_go   = owned && !run && rd_start;
  wire launch   = cmd_go || grant;
  wire [ADDR_W-1:0] go_addr = grant ? ADDR_W'(WAKE_ADDR) : rd_addr;
  wire in_phase = (cnt >= HDR_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_CFG;
      ext_m  <= 1'b0;
      ext_s  <= 1'b0;
      run    <= 1'b0;
      ph     <= 1'b0;
      cnt    <= '0;
      sh_out <= '0;
      sh_in  <= '0;
      done_q <= 1'b0;
    end else begin
      ext_m  <= ext_busy;
      ext_s  <= ext_m;
      done_q <= 1'b0;
      case (st)
        S_CFG:   if (!run && !rd_start && cfg_done) st <= S_IDLE;
        S_IDLE:  if (wake) st <= S_REQ;
        S_REQ:   if (!ext_s) st <= S_CFG;
        default: st <= S_CFG;
      endcase
      if (launch) begin
        run    <= 1'b1;
        ph     <= 1'b0;
        cnt    <= '0;
        sh_out <= {3'b110, go_addr};
      end else if (run) begin
        ph <= ~ph;
        if (ph) begin
          cnt <= cnt + 1'b1;
          if (in_phase) sh_in <= {sh_in[DATA_W-2:0], ee_sio_i};
          else          sh_out <= sh_out << 1;
          if (cnt == LAST_C) begin
            run    <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign own_busy  = (st != S_IDLE);
  assign ee_cs_oe  = owned;
  assign ee_sck_oe = owned;
  assign ee_cs_o   = owned && run;
  assign ee_sck_o  = owned && run && ph;
  assign ee_sio_oe = owned && !(run && in_phase);
  assign ee_sio_o  = owned && run && !in_phase && sh_out[HDR_W-1];
  assign rd_done   = done_q;
  assign rd_data   = sh_in;
  assign rd_busy   = run;
endmodule

// File: rtl/eeprom_share_ctl_chk.sv
module eeprom_share_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic own_busy,
  input logic ext_busy,
  input logic ee_cs_o,
  input logic ee_cs_oe,
  input logic ee_sck_o,
  input logic ee_sck_oe,
  input logic ee_sio_o,
  input logic ee_sio_oe,
  input logic rd_done
);
  p_oe_needs_own_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ee_cs_oe |-> own_busy);
  p_quiet_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs_oe |-> (!ee_cs_o && !ee_sck_o && !ee_sio_o && !ee_sio_oe && !ee_sck_oe));
  p_grant_ext_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs_oe) |-> !$past(ext_busy, 3));
  p_grant_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs_oe) |-> $past(own_busy));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);
  p_sio_owned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sio_oe |-> ee_cs_oe);
endmodule

bind eeprom_share_ctl eeprom_share_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .own_busy(own_busy), .ext_busy(ext_busy),
  .ee_cs_o(ee_cs_o), .ee_cs_oe(ee_cs_oe), .ee_sck_o(ee_sck_o),
  .ee_sck_oe(ee_sck_oe), .ee_sio_o(ee_sio_o), .ee_sio_oe(ee_sio_oe),
  .rd_done(rd_done)
);

// File: tb/sim_eeprom_share_ctl.sv
module sim_eeprom_share_ctl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int HDR = 3 + AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_done = 0, wake = 0, rd_start = 0, ext_busy = 0, ee_sio_i = 0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_done, rd_busy, own_busy;
  logic [DW-1:0] rd_data;
  logic ee_cs_o, ee_cs_oe, ee_sck_o, ee_sck_oe, ee_sio_o, ee_sio_oe;

  int n_chk = 0, n_fail = 0;
  int bitc = 0, oe_bad = 0, in_bits = 0;
  logic prev_sck = 0;
  logic [HDR-1:0] cap = '0;

  always #2 clk = ~clk;

  eeprom_share_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .wake(wake),
    .rd_start(rd_start), .rd_addr(rd_addr), .rd_done(rd_done),
    .rd_data(rd_data), .rd_busy(rd_busy), .own_busy(own_busy),
    .ext_busy(ext_busy), .ee_cs_o(ee_cs_o), .ee_cs_oe(ee_cs_oe),
    .ee_sck_o(ee_sck_o), .ee_sck_oe(ee_sck_oe), .ee_sio_o(ee_sio_o),
    .ee_sio_oe(ee_sio_oe), .ee_sio_i(ee_sio_i)
  );

  function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
    return DW'(32'(a) * 32'd313) ^ 16'hC3A5;
  endfunction

  always @(negedge clk) begin
    if (!rst_n || !ee_cs_o) begin
      bitc = 0;
    end else if (ee_sck_o && !prev_sck) begin
      if (bitc < HDR) begin
        cap = {cap[HDR-2:0], ee_sio_o};
        if (!ee_sio_oe) oe_bad++;
      end else begin
        ee_sio_i = model(cap[AW-1:0])[DW-1-(bitc-HDR)];
        if (ee_sio_oe) oe_bad++;
        in_bits++;
      end
      bitc++;
    end
    prev_sck = ee_sck_o;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(input logic [AW-1:0] a, input string tag);
    int k = 0;
    while (!rd_done && k < 300) begin @(negedge clk); k++; end
    chk(rd_done, {tag, " done seen"}, int'(rd_done), 1);
    chk(rd_data == model(a), {tag, " R9 data"}, int'(rd_data), int'(model(a)));
    chk(cap == {3'b110, a}, {tag, " R8 frame"}, int'(cap), int'({3'b110, a}));
    @(negedge clk);
    chk(!rd_done, {tag, " R9 pulse width"}, int'(rd_done), 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    rd_start = 1; rd_addr = a;
    @(negedge clk);
    rd_start = 0;
    wait_done(a, "R8/R9 read");
  endtask

  task automatic release_bus;
    cfg_done = 1;
    @(negedge clk);
    cfg_done = 0;
    chk(!own_busy && !ee_cs_oe && !ee_sck_oe && !ee_sio_oe, "R2 release",
        int'({own_busy, ee_cs_oe, ee_sck_oe, ee_sio_oe}), 0);
    chk(!ee_cs_o && !ee_sck_o && !ee_sio_o, "R3 released low",
        int'({ee_cs_o, ee_sck_o, ee_sio_o}), 0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(own_busy && ee_cs_oe && ee_sck_oe && !ee_cs_o, "R1 reset owner",
        int'({own_busy, ee_cs_oe, ee_sck_oe, ee_cs_o}), 4'b1110);

    for (int a = 0; a < 256; a++) do_read(AW'(a));
    chk(oe_bad == 0 && in_bits == 256 * DW, "R10 sio enable turnaround", oe_bad, 0);

    release_bus();

    bad = 0;
    rd_start = 1; rd_addr = 8'h55;
    @(negedge clk);
    rd_start = 0;
    for (int i = 0; i < 60; i++) begin
      if (ee_cs_oe || ee_cs_o || rd_done || rd_busy) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R11 rd_start ignored when released", bad, 0);

    wake = 1;
    @(negedge clk);
    wake = 0;
    chk(own_busy && !ee_cs_oe, "R6 request cycle", int'({own_busy, ee_cs_oe}), 2'b10);
    @(negedge clk);
    chk(ee_cs_oe && ee_cs_o, "R6 grant cycle", int'({ee_cs_oe, ee_cs_o}), 2'b11);
    wait_done(8'h0E, "R7 wake read");

    ext_busy = 1;
    do_read(8'h33);
    chk(ee_cs_oe, "R11 ext ignored while owning", int'(ee_cs_oe), 1);
    ext_busy = 0;
    repeat (3) @(negedge clk);
    release_bus();
    repeat (4) @(negedge clk);

    ext_busy = 1;
    @(negedge clk);
    wake = 1;
    @(negedge clk);
    wake = 0;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      if (!own_busy || ee_cs_oe || ee_sck_oe || ee_sio_oe) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R4 hold off while external owns", bad, 0);
    ext_busy = 0;
    @(negedge clk);
    chk(!ee_cs_oe, "R4 no enable one after drop", int'(ee_cs_oe), 0);
    @(negedge clk);
    chk(!ee_cs_oe, "R4 no enable two after drop", int'(ee_cs_oe), 0);
    @(negedge clk);
    chk(ee_cs_oe && ee_cs_o, "R4 enable three after drop", int'({ee_cs_oe, ee_cs_o}), 2'b11);
    wait_done(8'h0E, "R7 wake read after handoff");
    release_bus();
    repeat (4) @(negedge clk);

    ext_busy = 1; wake = 1;
    @(negedge clk);
    wake = 0;
    chk(own_busy && !ee_cs_oe, "R5 race request", int'({own_busy, ee_cs_oe}), 2'b10);
    @(negedge clk);
    chk(ee_cs_oe, "R5 block wins race", int'(ee_cs_oe), 1);
    wait_done(8'h0E, "R5 read after race");
    ext_busy = 0;
    chk(oe_bad == 0, "R10 sio enable over all frames", oe_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule